// File: doc/BRIEF.md
# Timer Count-Clock Prescaler and Free-Running Counter

This block keeps a free-running 16-bit timer count and decides when that count advances. All logic runs in the bus-clock domain. The count advances on a single-cycle enable pulse, and no clock is ever derived. There are two prescaler options. The first divides the bus clock by a power of two chosen by a 3-bit code. The second is a fine 8-bit divider that, when enabled, takes the place of the power-of-two stage. A source selector then chooses the count-advance pulse from four candidates: the prescaler pulse, the external accumulator clock-enable pulse as it arrives, or that pulse stream divided by 256 or by 65536.

When the count wraps from its all-ones value back to zero, the block sets an overflow flag. The interrupt output is high whenever that flag and the overflow interrupt enable are both set. A run bit stops all counting while it is clear. Software drives the block through a small byte-wide write port with four addresses. Writing a 1 to bit 0 of the status address clears the overflow flag, unless an overflow happens in that same cycle.

Top module: `tmr_clkcnt`

## Requirements
- R1: After synchronous reset, the count is 0, the overflow flag is 0, the interrupt is 0 and every control field is 0. With run clear, the count stays at 0.
- R2: Set address 1 bits [5:4] to 0 (prescaler source) and address 0 bit 1 to 0 (fine divider off). A code n in address 1 bits [2:0] then makes the count advance once every 2^n bus cycles.
- R3: Set address 0 bit 1 to 1. The fine value V in address 2 then makes the count advance once every V+1 bus cycles, whatever the power-of-two code holds.
- R4: The source code in address 1 bits [5:4] works as follows. Code 0 uses the prescaler. Code 1 advances the count once per accumulator pulse. Code 2 advances it once per 256 pulses. Code 3 advances it once per 65536 pulses.
- R5: While the run bit (address 0 bit 0) is 0, the count does not change. Once run is set again, counting resumes.
- R6: A write that changes the power-of-two code, the fine value or the fine-enable bit restarts the prescaler's divider. With code n, the first advance then lands exactly 2^n cycles after the write edge.
- R7: When the count wraps from 0xFFFF to 0x0000, the overflow flag is set in that same edge.
- R8: Writing to address 3 with bit 0 at 1 clears the flag. Writing with bit 0 at 0 leaves the flag unchanged.
- R9: If a clear write and an overflow happen in the same cycle, the clear is ignored and the flag stays at 1.
- R10: The interrupt output equals the overflow flag ANDed with the interrupt enable (address 0 bit 2). Clearing either one drops the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 select, 2 fine value, 3 status clear) |
| wr_data | input | 8 | Register write data |
| acc_clk_en | input | 1 | Accumulator clock-enable pulse, one bus cycle per event |
| count_o | output | 16 | Current timer count |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions watch several things on every cycle. The count holds while run is clear and otherwise steps by exactly one per advance pulse. The prescaler's divider never passes its limit and returns to zero after a restart. The accumulator divider steps once per pulse. The flag is set on every wrap, a clear that meets a wrap loses, and a clear on its own takes effect. Only the bench scenarios can show the real divide ratios for each code, fine value and source, the exact latency after a prescale change, and the interrupt gating seen at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;
  localparam int POW_W  = 3;
  localparam int FINE_W = 8;

  localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] A_SEL  = 2'd1;
  localparam logic [REG_AW-1:0] A_FINE = 2'd2;
  localparam logic [REG_AW-1:0] A_STAT = 2'd3;

  typedef enum logic [1:0] {
    SRC_PRESC  = 2'd0,
    SRC_ACC    = 2'd1,
    SRC_ACC_LO = 2'd2,
    SRC_ACC_HI = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic              run;
    logic              fine;
    logic              ovf_ie;
    logic [POW_W-1:0]  pow;
    clk_src_e          src;
    logic [FINE_W-1:0] fine_div;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output tmr_cfg_t          cfg_o,
  output logic              restart_o,
  output logic              ovf_clr_o
);
  tmr_cfg_t cfg_q;

  // Divider restart only when a prescale-relevant field actually changes
  always_comb begin
    restart_o = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL:  restart_o = (wr_data[1] != cfg_q.fine);
        A_SEL:   restart_o = (wr_data[POW_W-1:0] != cfg_q.pow);
        A_FINE:  restart_o = (wr_data[FINE_W-1:0] != cfg_q.fine_div);
        default: restart_o = 1'b0;
      endcase
    end
  end

  assign ovf_clr_o = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          cfg_q.run    <= wr_data[0];
          cfg_q.fine   <= wr_data[1];
          cfg_q.ovf_ie <= wr_data[2];
        end
        A_SEL: begin
          cfg_q.pow <= wr_data[POW_W-1:0];
          cfg_q.src <= clk_src_e'(wr_data[5:4]);
        end
        A_FINE:  cfg_q.fine_div <= wr_data[FINE_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             fine_en,
  input  logic [SEL_W-1:0] pow_sel,
  input  logic [DIV_W-1:0] fine_div,
  input  logic             restart,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] pow_lim;
  logic [DIV_W-1:0] limit;

  assign pow_lim = (ONE << pow_sel) - ONE;
  assign limit   = fine_en ? fine_div : pow_lim;
  assign tick_o  = run && (div_cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || restart)
      div_cnt <= '0;
    else if (run)
      div_cnt <= tick_o ? '0 : div_cnt + ONE;
  end

  assert_div_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= limit);
  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (div_cnt == '0));
endmodule

// File: rtl/tmr_accdiv.sv
module tmr_accdiv #(
  parameter int LO_W = 8,
  parameter int HI_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic acc_en,
  output logic tick_1_o,
  output logic tick_lo_o,
  output logic tick_hi_o
);
  logic [HI_W-1:0] acc_cnt;

  assign tick_1_o  = run && acc_en;
  assign tick_lo_o = tick_1_o && (acc_cnt[LO_W-1:0] == '1);
  assign tick_hi_o = tick_1_o && (acc_cnt == '1);

  always_ff @(posedge clk) begin
    if (rst)
      acc_cnt <= '0;
    else if (tick_1_o)
      acc_cnt <= acc_cnt + HI_W'(1);
  end

  assert_acc_step_R4: assert property (@(posedge clk) disable iff (rst)
    tick_1_o |=> (acc_cnt == HI_W'($past(acc_cnt) + HI_W'(1))));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  input  logic             ovf_ie,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             step;
  logic             wrap;

  assign step = run && tick;
  assign wrap = step && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (step)
        cnt_q <= cnt_q + CNT_W'(1);
      if (wrap)
        flag_q <= 1'b1;
      else if (clr)
        flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q && ovf_ie;

  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_q));
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
  assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (flag_q && (cnt_q == '0)));
  assert_clear_loses_R9: assert property (@(posedge clk) disable iff (rst)
    (wrap && clr) |=> flag_q);
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !wrap) |=> !flag_q);
endmodule

// File: rtl/tmr_clkcnt.sv
module tmr_clkcnt
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ACC_LO_W = 8,
  parameter int ACC_HI_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic              acc_clk_en,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_flag_o,
  output logic              irq_o
);
  tmr_cfg_t cfg;
  logic     restart;
  logic     ovf_clr;
  logic     ps_tick;
  logic     acc_t1, acc_tlo, acc_thi;
  logic     cnt_tick;

  tmr_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_o(cfg), .restart_o(restart), .ovf_clr_o(ovf_clr)
  );

  tmr_presc #(.DIV_W(FINE_W), .SEL_W(POW_W)) u_presc (
    .clk(clk), .rst(rst), .run(cfg.run), .fine_en(cfg.fine),
    .pow_sel(cfg.pow), .fine_div(cfg.fine_div), .restart(restart),
    .tick_o(ps_tick)
  );

  tmr_accdiv #(.LO_W(ACC_LO_W), .HI_W(ACC_HI_W)) u_acc (
    .clk(clk), .rst(rst), .run(cfg.run), .acc_en(acc_clk_en),
    .tick_1_o(acc_t1), .tick_lo_o(acc_tlo), .tick_hi_o(acc_thi)
  );

  always_comb begin
    case (cfg.src)
      SRC_PRESC:  cnt_tick = ps_tick;
      SRC_ACC:    cnt_tick = acc_t1;
      SRC_ACC_LO: cnt_tick = acc_tlo;
      default:    cnt_tick = acc_thi;
    endcase
  end

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(cfg.run), .tick(cnt_tick), .clr(ovf_clr),
    .ovf_ie(cfg.ovf_ie), .cnt_o(count_o), .flag_o(ovf_flag_o), .irq_o(irq_o)
  );
endmodule

// File: tb/sim_tmr_clkcnt.sv
`timescale 1ns/1ps
module sim_tmr_clkcnt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        acc_clk_en = 1'b0;
  logic [15:0] count_o;
  logic        ovf_flag_o;
  logic        irq_o;

  int unsigned cyc = 0;
  int unsigned acc_mode = 0;
  int checks = 0;
  int fails = 0;

  tmr_clkcnt u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .acc_clk_en(acc_clk_en), .count_o(count_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) acc_clk_en <= (acc_mode != 0) && ((cyc % acc_mode) == 0);

  // fields: [31] fine_en, [30:28] pow, [27:20] fine, [19:18] src, [17:16] acc pulse spacing, [15:0] period
  localparam logic [31:0] VEC [15] = '{
    {1'b0, 3'd0, 8'd0,   2'd0, 2'd0, 16'd1},   // R2
    {1'b0, 3'd1, 8'd0,   2'd0, 2'd0, 16'd2},   // R2
    {1'b0, 3'd2, 8'd0,   2'd0, 2'd0, 16'd4},   // R2
    {1'b0, 3'd3, 8'd0,   2'd0, 2'd0, 16'd8},   // R2
    {1'b0, 3'd4, 8'd0,   2'd0, 2'd0, 16'd16},  // R2
    {1'b0, 3'd5, 8'd0,   2'd0, 2'd0, 16'd32},  // R2
    {1'b0, 3'd6, 8'd0,   2'd0, 2'd0, 16'd64},  // R2
    {1'b0, 3'd7, 8'd0,   2'd0, 2'd0, 16'd128}, // R2
    {1'b1, 3'd5, 8'd0,   2'd0, 2'd0, 16'd1},   // R3
    {1'b1, 3'd5, 8'd4,   2'd0, 2'd0, 16'd5},   // R3
    {1'b1, 3'd2, 8'd199, 2'd0, 2'd0, 16'd200}, // R3
    {1'b0, 3'd0, 8'd0,   2'd1, 2'd1, 16'd1},   // R4
    {1'b0, 3'd0, 8'd0,   2'd1, 2'd2, 16'd2},   // R4
    {1'b0, 3'd0, 8'd0,   2'd2, 2'd1, 16'd256}, // R4
    {1'b0, 3'd0, 8'd0,   2'd2, 2'd2, 16'd512}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_change(output int unsigned t);
    logic [15:0] p;
    p = count_o;
    do @(negedge clk); while (count_o == p);
    t = cyc;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned ta, tb, c0;
    logic [15:0] p;
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count", {16'd0, count_o}, 32'd0);
    chk("R1 flag", {31'd0, ovf_flag_o}, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R1 idle count", {16'd0, count_o}, 32'd0);

    // ratio table: R2 R3 R4
    for (int i = 0; i < 15; i++) begin
      v = VEC[i];
      acc_mode = {30'd0, v[17:16]};
      wr(2'd0, {6'd0, v[31], 1'b1});
      wr(2'd1, {2'b00, v[19:18], 1'b0, v[30:28]});
      wr(2'd2, v[27:20]);
      wait_change(ta);
      wait_change(tb);
      chk($sformatf("R2/R3/R4 period vec%0d", i), tb - ta, {16'd0, v[15:0]});
    end
    acc_mode = 1;

    // R4: source code 3 needs 65536 pulses; far fewer have arrived
    wr(2'd1, 8'h30);
    p = count_o;
    repeat (1000) @(negedge clk);
    chk("R4 div65536 no step", {16'd0, count_o}, {16'd0, p});
    acc_mode = 0;

    // R5: run cleared holds the count
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    p = count_o;
    repeat (50) @(negedge clk);
    chk("R5 hold", {16'd0, count_o}, {16'd0, p});
    wr(2'd0, 8'h01);
    repeat (5) @(negedge clk);
    chk("R5 resume", {31'd0, count_o != p}, 32'd1);

    // R6: divider restart on code change
    wr(2'd1, 8'h07);
    repeat (40) @(negedge clk);
    wr(2'd1, 8'h06);
    c0 = cyc;
    wait_change(ta);
    chk("R6 first step latency", ta - c0, 32'd64);

    // R7 R8 R9 R10: overflow
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h05);
    while (count_o != 16'hFFFF) @(negedge clk);
    @(negedge clk);
    chk("R7 wrap count", {16'd0, count_o}, 32'd0);
    chk("R7 flag set", {31'd0, ovf_flag_o}, 32'd1);
    chk("R10 irq set", {31'd0, irq_o}, 32'd1);
    wr(2'd3, 8'h00);
    chk("R8 zero write keeps flag", {31'd0, ovf_flag_o}, 32'd1);
    wr(2'd0, 8'h01);
    chk("R10 irq masked", {31'd0, irq_o}, 32'd0);
    chk("R10 flag kept", {31'd0, ovf_flag_o}, 32'd1);
    wr(2'd0, 8'h05);
    chk("R10 irq unmasked", {31'd0, irq_o}, 32'd1);
    wr(2'd3, 8'h01);
    chk("R8 clear flag", {31'd0, ovf_flag_o}, 32'd0);
    chk("R10 irq drops", {31'd0, irq_o}, 32'd0);
    while (count_o != 16'hFFFF) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 collide flag", {31'd0, ovf_flag_o}, 32'd1);
    chk("R9 collide count", {16'd0, count_o}, 32'd0);
    wr(2'd3, 8'h01);
    chk("R8 later clear", {31'd0, ovf_flag_o}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule